// File: doc/BRIEF.md
# Load/Store and Branch Effective Address Unit

This unit forms the virtual address of every memory access and every PC-relative branch in a 64-bit load/store core. A memory operation adds a base register value to a signed 16-bit offset. A branch scales a signed 21-bit word offset by four and adds it to the address of the following instruction. The unit also decides from the value of a condition register whether the branch is taken. It flags naturally misaligned accesses and splits the resulting address into a page number and a byte offset within an 8 KB page.

One operation is accepted per cycle. The results appear on registered outputs one clock later. When no operation is accepted, the outputs keep their last values. An unaligned-quadword form rounds the address down to an 8-byte boundary. That form never raises the alignment flag, so later byte extraction can work on the containing quadword. Byte numbering is little-endian throughout, so the low address bits select bytes starting from the least significant one.

Top module: `agu_top`

## Requirements
- R1: With `op`=00 (aligned memory), `addr` equals `base` plus `disp` sign-extended from 16 to 64 bits, taken modulo 2^64.
- R2: With `op`=01 (unaligned quadword), `addr` equals the R1 sum with its three low bits forced to zero, and `align_fault` is 0.
- R3: With `op`=00, `align_fault` is 1 exactly when the sum's low bits are not all zero for the access size: `size` 00 = 1 byte (never faults), 01 = 2 bytes (bit 0), 10 = 4 bytes (bits 1:0), 11 = 8 bytes (bits 2:0). For `op`=10 (branch), `align_fault` is 0.
- R4: With `op`=10, `addr` equals `pc` + 4 + (`bdisp` sign-extended from 21 bits) × 4, taken modulo 2^64.
- R5: With `op`=10, `taken` follows `cond`: 000 always, 001 when `cond_val` is zero, 010 when it is nonzero, 011 when it is negative as a signed value, 100 when it is non-negative as a signed value; codes 101 to 111 are never taken.
- R6: `next_pc` equals `addr` when `taken` is 1, and `pc` + 4 otherwise. Memory operations always give `taken` = 0.
- R7: `page_num` equals `addr` bits 63:13 and `page_off` equals `addr` bits 12:0.
- R8: An operation accepted at a clock edge (`in_valid`=1 with `op` not 11) sets `out_valid` and all result outputs at that edge. When `in_valid` is 0 or `op` is 11, `out_valid` is 0 after the edge and every other output keeps its value.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| op | input | 2 | 00 aligned memory, 01 unaligned quadword, 10 branch, 11 none |
| size | input | 2 | Memory access size code (see R3) |
| cond | input | 3 | Branch condition code (see R5) |
| base | input | 64 | Base register value for memory operations |
| cond_val | input | 64 | Register value tested by branches |
| pc | input | 64 | Address of the current instruction |
| disp | input | 16 | Signed memory offset |
| bdisp | input | 21 | Signed branch offset in instructions |
| out_valid | output | 1 | Result registered this cycle |
| addr | output | 64 | Effective or target address |
| next_pc | output | 64 | Address of the next instruction to fetch |
| taken | output | 1 | Branch taken |
| align_fault | output | 1 | Misaligned access |
| page_num | output | 51 | Virtual page number of `addr` |
| page_off | output | 13 | Byte offset of `addr` within its page |

## Verification
The bench drives offsets at both ends of the signed range and base values that push the sum across zero and past the 64-bit wrap. A unit that zero-extends or truncates an offset lands far from the expected address. Every combination of access size and low three address bits is tried in both memory forms, so a wrong mask width, or a fault raised for the rounding form, gives a wrong flag. Every condition code is applied to zero, one, minus one and the two signed extremes, which exposes an unsigned comparison or a swapped code. Branch offsets at the 21-bit extremes catch a target built from `pc` instead of `pc`+4, or one shifted the wrong way. Idle cycles and `op` 11 between operations show that results are held and not overwritten.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        OP_MEM    = 2'b00,
        OP_MEM_UQ = 2'b01,
        OP_BRANCH = 2'b10,
        OP_NONE   = 2'b11
    } agu_op_e;

    typedef enum logic [2:0] {
        BC_ALWAYS = 3'b000,
        BC_EQZ    = 3'b001,
        BC_NEZ    = 3'b010,
        BC_LTZ    = 3'b011,
        BC_GEZ    = 3'b100
    } agu_cond_e;

    localparam int unsigned SIZE_CODES = 4;

endpackage

// File: rtl/agu_mem_addr.sv
module agu_mem_addr #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size,
    input  logic              round_qw,
    output logic [XLEN-1:0]   ea,
    output logic              fault
);
    localparam int unsigned EXT_W  = XLEN - DISP_W;
    localparam int unsigned QW_LSB = 3;
    localparam int unsigned NSIZE  = agu_pkg::SIZE_CODES;

    logic [XLEN-1:0]  sum;
    logic [NSIZE-1:0] mis;

    assign sum = base + {{EXT_W{disp[DISP_W-1]}}, disp};

    // one misalignment bit per size code; size code s covers 2**s bytes
    assign mis[0] = 1'b0;
    for (genvar g = 1; g < NSIZE; g++) begin : g_mis
        assign mis[g] = |sum[g-1:0];
    end

    assign ea    = round_qw ? {sum[XLEN-1:QW_LSB], {QW_LSB{1'b0}}} : sum;
    assign fault = !round_qw && mis[size];

endmodule

// File: rtl/agu_branch.sv
module agu_branch #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned BDISP_W = 21
) (
    input  logic [XLEN-1:0]    pc,
    input  logic [BDISP_W-1:0] bdisp,
    input  logic [XLEN-1:0]    cond_val,
    input  logic [2:0]         cond,
    output logic [XLEN-1:0]    target,
    output logic [XLEN-1:0]    seq_pc,
    output logic               taken
);
    import agu_pkg::*;

    localparam int unsigned SHIFT      = 2;
    localparam int unsigned INSN_BYTES = 1 << SHIFT;
    localparam int unsigned EXT_W      = XLEN - BDISP_W - SHIFT;

    logic [XLEN-1:0] offset;
    logic            is_zero;
    logic            is_neg;

    assign seq_pc  = pc + XLEN'(INSN_BYTES);
    assign offset  = {{EXT_W{bdisp[BDISP_W-1]}}, bdisp, {SHIFT{1'b0}}};
    assign target  = seq_pc + offset;
    assign is_zero = (cond_val == '0);
    assign is_neg  = cond_val[XLEN-1];

    always_comb begin
        case (agu_cond_e'(cond))
            BC_ALWAYS: taken = 1'b1;
            BC_EQZ:    taken = is_zero;
            BC_NEZ:    taken = !is_zero;
            BC_LTZ:    taken = is_neg;
            BC_GEZ:    taken = !is_neg;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/agu_page_split.sv
module agu_page_split #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned PAGE_W = 13
) (
    input  logic [XLEN-1:0]        addr,
    output logic [XLEN-PAGE_W-1:0] vpn,
    output logic [PAGE_W-1:0]      offset
);
    assign vpn    = addr[XLEN-1:PAGE_W];
    assign offset = addr[PAGE_W-1:0];
endmodule

// File: rtl/agu_top.sv
module agu_top #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned BDISP_W = 21,
    parameter int unsigned PAGE_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               op,
    input  logic [1:0]               size,
    input  logic [2:0]               cond,
    input  logic [XLEN-1:0]          base,
    input  logic [XLEN-1:0]          cond_val,
    input  logic [XLEN-1:0]          pc,
    input  logic [DISP_W-1:0]        disp,
    input  logic [BDISP_W-1:0]       bdisp,
    output logic                     out_valid,
    output logic [XLEN-1:0]          addr,
    output logic [XLEN-1:0]          next_pc,
    output logic                     taken,
    output logic                     align_fault,
    output logic [XLEN-PAGE_W-1:0]   page_num,
    output logic [PAGE_W-1:0]        page_off
);
    import agu_pkg::*;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] next_pc;
        logic            taken;
        logic            fault;
    } res_t;

    res_t res_d, res_q;

    logic [XLEN-1:0] mem_ea;
    logic            mem_fault;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] br_seq;
    logic            br_taken;

    agu_mem_addr #(.XLEN(XLEN), .DISP_W(DISP_W)) u_mem (
        .base     (base),
        .disp     (disp),
        .size     (size),
        .round_qw (op == OP_MEM_UQ),
        .ea       (mem_ea),
        .fault    (mem_fault)
    );

    agu_branch #(.XLEN(XLEN), .BDISP_W(BDISP_W)) u_br (
        .pc       (pc),
        .bdisp    (bdisp),
        .cond_val (cond_val),
        .cond     (cond),
        .target   (br_target),
        .seq_pc   (br_seq),
        .taken    (br_taken)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (in_valid) begin
            case (agu_op_e'(op))
                OP_MEM, OP_MEM_UQ: begin
                    res_d.valid   = 1'b1;
                    res_d.addr    = mem_ea;
                    res_d.next_pc = br_seq;
                    res_d.taken   = 1'b0;
                    res_d.fault   = mem_fault;
                end
                OP_BRANCH: begin
                    res_d.valid   = 1'b1;
                    res_d.addr    = br_target;
                    res_d.next_pc = br_taken ? br_target : br_seq;
                    res_d.taken   = br_taken;
                    res_d.fault   = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    agu_page_split #(.XLEN(XLEN), .PAGE_W(PAGE_W)) u_page (
        .addr   (res_q.addr),
        .vpn    (page_num),
        .offset (page_off)
    );

    assign out_valid   = res_q.valid;
    assign addr        = res_q.addr;
    assign next_pc     = res_q.next_pc;
    assign taken       = res_q.taken;
    assign align_fault = res_q.fault;

endmodule

// File: rtl/agu_checks.sv
module agu_checks #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned BDISP_W = 21,
    parameter int unsigned PAGE_W  = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [1:0]             op,
    input logic [2:0]             cond,
    input logic [XLEN-1:0]        base,
    input logic [XLEN-1:0]        pc,
    input logic [DISP_W-1:0]      disp,
    input logic [BDISP_W-1:0]     bdisp,
    input logic                   out_valid,
    input logic [XLEN-1:0]        addr,
    input logic [XLEN-1:0]        next_pc,
    input logic                   taken,
    input logic                   align_fault
);
    localparam int unsigned MEXT = XLEN - DISP_W;
    localparam int unsigned BEXT = XLEN - BDISP_W - 2;

    // R1: aligned memory address is base plus sign-extended offset
    a_r1_mem_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b00) |->
        addr == $past(base) + {{MEXT{$past(disp[DISP_W-1])}}, $past(disp)});

    // R2: unaligned quadword form is 8-byte rounded and never faults
    a_r2_uq_round: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b01) |-> (addr[2:0] == 3'b000 && !align_fault));

    // R3: branches never flag misalignment
    a_r3_branch_nofault: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b10) |-> !align_fault);

    // R4: branch target from the following instruction address
    a_r4_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b10) |->
        addr == $past(pc) + 64'd4 + {{BEXT{$past(bdisp[BDISP_W-1])}}, $past(bdisp), 2'b00});

    // R5: unconditional code always taken
    a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b10 && $past(cond) == 3'b000) |-> taken);

    // R6: fall-through address when not taken
    a_r6_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> next_pc == $past(pc) + 64'd4);

    // R8: nothing accepted means no valid and held results
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) || $past(op) == 2'b11) |->
        (!out_valid && $stable(addr) && $stable(next_pc) && $stable(taken)));

endmodule

bind agu_top agu_checks #(
    .XLEN(XLEN), .DISP_W(DISP_W), .BDISP_W(BDISP_W), .PAGE_W(PAGE_W)
) u_agu_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op          (op),
    .cond        (cond),
    .base        (base),
    .pc          (pc),
    .disp        (disp),
    .bdisp       (bdisp),
    .out_valid   (out_valid),
    .addr        (addr),
    .next_pc     (next_pc),
    .taken       (taken),
    .align_fault (align_fault)
);

// File: tb/test_agu_top.sv
module test_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b11;
    logic [1:0]  size = 2'b00;
    logic [2:0]  cond = 3'b000;
    logic [63:0] base = '0, cond_val = '0, pc = '0;
    logic [15:0] disp = '0;
    logic [20:0] bdisp = '0;
    logic        out_valid, taken, align_fault;
    logic [63:0] addr, next_pc;
    logic [50:0] page_num;
    logic [12:0] page_off;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    agu_top i_agu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .cond(cond), .base(base), .cond_val(cond_val), .pc(pc), .disp(disp),
        .bdisp(bdisp), .out_valid(out_valid), .addr(addr), .next_pc(next_pc),
        .taken(taken), .align_fault(align_fault), .page_num(page_num),
        .page_off(page_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, result sampled at the following falling edge
    task automatic issue(input logic v, input logic [1:0] o, input logic [1:0] sz,
                         input logic [2:0] c, input logic [63:0] b, input logic [63:0] cv,
                         input logic [63:0] p, input logic [15:0] d, input logic [20:0] bd);
        in_valid = v; op = o; size = sz; cond = c; base = b; cond_val = cv;
        pc = p; disp = d; bdisp = bd;
        @(negedge clk);
    endtask

    task automatic check_page();
        chk("R7 page_num", {13'd0, page_num}, addr >> 13);
        chk("R7 page_off", {51'd0, page_off}, addr & 64'h1FFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] bases [5];
        logic [15:0] disps [5];
        logic [63:0] cvals [5];
        logic [20:0] bds [5];
        bases = '{64'h0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFF8, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_1234_5678_9AB0};
        disps = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        cvals = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
        bds   = '{21'h0, 21'h1, 21'h0F_FFFF, 21'h10_0000, 21'h1F_FFFF};

        @(negedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 addr", addr, 64'd0);
        chk("R9 next_pc", next_pc, 64'd0);
        chk("R9 flags", {62'd0, taken, align_fault}, 64'd0);
        chk("R9 page", {page_num, page_off}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: memory sweep over sizes, low bits and offsets
        for (int o = 0; o < 2; o++)
            for (int bi = 0; bi < 5; bi++)
                for (int di = 0; di < 5; di++)
                    for (int lo = 0; lo < 8; lo++)
                        for (int sz = 0; sz < 4; sz++) begin
                            logic [63:0] b, sum, exp_a;
                            logic        exp_f;
                            b = bases[bi] + 64'(lo);
                            sum = b + {{48{disps[di][15]}}, disps[di]};
                            exp_a = (o == 1) ? (sum & ~64'h7) : sum;
                            exp_f = (o == 0) && ((sum & ((64'd1 << sz) - 64'd1)) != 0);
                            issue(1'b1, 2'(o), 2'(sz), 3'd0, b, 64'd0, 64'h4000, disps[di], 21'd0);
                            chk("R8 valid mem", {63'd0, out_valid}, 64'd1);
                            chk(o == 0 ? "R1 mem addr" : "R2 uq addr", addr, exp_a);
                            chk(o == 0 ? "R3 align_fault" : "R2 uq no fault", {63'd0, align_fault}, {63'd0, exp_f});
                            chk("R6 mem not taken", {63'd0, taken}, 64'd0);
                            chk("R6 mem next_pc", next_pc, 64'h4004);
                            check_page();
                        end

        // R4 R5 R6: branch sweep
        for (int c = 0; c < 8; c++)
            for (int vi = 0; vi < 5; vi++)
                for (int bi = 0; bi < 5; bi++) begin
                    logic [63:0] p, tgt;
                    logic        exp_t;
                    p = 64'h0000_0000_0010_0000 + 64'(vi * 8);
                    tgt = p + 64'd4 + {{41{bds[bi][20]}}, bds[bi], 2'b00};
                    case (c)
                        0: exp_t = 1'b1;
                        1: exp_t = (cvals[vi] == 0);
                        2: exp_t = (cvals[vi] != 0);
                        3: exp_t = ($signed(cvals[vi]) < 0);
                        4: exp_t = ($signed(cvals[vi]) >= 0);
                        default: exp_t = 1'b0;
                    endcase
                    issue(1'b1, 2'b10, 2'b11, 3'(c), 64'h3, cvals[vi], p, 16'h0001, bds[bi]);
                    chk("R8 valid br", {63'd0, out_valid}, 64'd1);
                    chk("R4 target", addr, tgt);
                    chk("R5 taken", {63'd0, taken}, {63'd0, exp_t});
                    chk("R6 next_pc", next_pc, exp_t ? tgt : p + 64'd4);
                    chk("R3 branch no fault", {63'd0, align_fault}, 64'd0);
                    check_page();
                end

        // R8: idle and op 11 leave results untouched
        issue(1'b1, 2'b00, 2'b10, 3'd0, 64'h2002, 64'd0, 64'h500, 16'h0001, 21'd0);
        chk("R8 setup addr", addr, 64'h2003);
        issue(1'b0, 2'b00, 2'b00, 3'd0, 64'h9990, 64'd0, 64'h700, 16'h0010, 21'd0);
        chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R8 idle addr held", addr, 64'h2003);
        chk("R8 idle fault held", {63'd0, align_fault}, 64'd1);
        issue(1'b1, 2'b11, 2'b00, 3'd0, 64'h8880, 64'd0, 64'h900, 16'h0020, 21'd5);
        chk("R8 op11 valid", {63'd0, out_valid}, 64'd0);
        chk("R8 op11 addr held", addr, 64'h2003);
        chk("R8 op11 next_pc held", next_pc, 64'h504);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule